// File: doc/BRIEF.md
# Per-Instruction Stride Learning Table

This block watches a stream of memory accesses, each tagged with the address of the instruction that made it. It learns, for every instruction it tracks, the distance between that instruction's consecutive data addresses. The table is fully associative. Every lookup compares the instruction address against all entries at once. If no entry matches, the least recently used entry is claimed for the new instruction. If an entry matches, its stride and its confirmation count are updated. The touched entry then becomes the most recently used one.

The block reports a registered result one cycle after each request strobe: whether the instruction was already known, its current stride, and whether that stride is confirmed. A prefetch engine further down the pipeline can use a confirmed stride to pick its next target.

Top module: `stride_table`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any instruction address is a miss, and `rsp_valid` is 0 until a request is made.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1, and is 0 otherwise.
- R3: On a miss the response shows `rsp_hit`=0, `rsp_stride`=0 and `rsp_trained`=0. The claimed entry stores the instruction address, takes the request's data address as its last address, and has stride 0 and count 0.
- R4: On a hit the candidate stride is the request data address minus the stored last address, taken as a 32-bit two's-complement difference with wrap-around. The stored last address then becomes the request data address.
- R5: On a hit whose candidate stride is nonzero and equal to the stored stride, the count increments and the response shows `rsp_trained`=1 with the unchanged stride.
- R6: On a hit whose candidate stride is zero or differs from the stored stride, the stored stride becomes the candidate, the count returns to 0, and the response shows `rsp_trained`=0 with the new stride.
- R7: While any entry is invalid, a miss claims an invalid entry, so the first ENTRIES distinct instruction addresses are all retained.
- R8: When all entries are valid, a miss replaces the entry touched longest ago. Every hit or miss makes the touched entry the most recent.
- R9: The repeat count saturates at its maximum instead of wrapping, and a long run of one stride keeps `rsp_trained`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_pc | input | 32 | Instruction address of the access |
| req_addr | input | 32 | Data address of the access |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_hit | output | 1 | Instruction address was already in the table |
| rsp_stride | output | 32 | Current stride of the entry, two's complement |
| rsp_trained | output | 1 | Stride confirmed by a repeat |

## Verification
A single instruction address is driven first with steady positive strides, then with a repeated address, then with negative and wrapping differences. This separates the repeat, zero and change cases of the stride update. A fill-then-overflow sequence with one refreshed entry shows that invalid entries are claimed before valid ones and that the oldest entry, not the refreshed one, is evicted. A long constant-stride run exercises count saturation. A random mix of six instruction addresses over a four-entry table is then compared with a queue-based reference every clock. That mix stresses the recency order under constant eviction pressure.

// File: rtl/stride_pkg.sv
package stride_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic signed [ADDR_W-1:0] stride_t;
endpackage

// File: rtl/stride_match.sv
module stride_match import stride_pkg::*; #(
  parameter int ENTRIES = 256,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  addr_t              tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  addr_t              key,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (match_vec[j]) hit_idx = IDX_W'(j);
  end

  assign hit = |match_vec;

  // R4: a given instruction address may live in at most one entry
  assert_single_match_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
endmodule

// File: rtl/stride_lru.sv
module stride_lru #(
  parameter int ENTRIES = 256,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   rank_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) rank_q[j] <= IDX_W'(j);
    end else if (touch) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touch_idx)             rank_q[j] <= '0;
        else if (rank_q[j] < rank_q[touch_idx]) rank_q[j] <= rank_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      oldest_vec[j] = (rank_q[j] == OLDEST);
      if (oldest_vec[j]) victim_idx = IDX_W'(j);
    end
  end

  // R8: the recency ranks stay a permutation, so exactly one entry is oldest
  assert_one_oldest_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
  // R8: a touched entry is the most recent one afterwards
  assert_touch_newest_R8: assert property (@(posedge clk) disable iff (rst)
    touch |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/stride_table.sv
module stride_table import stride_pkg::*; #(
  parameter int ENTRIES = 256,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_stride,
  output logic              rsp_trained
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ENTRIES-1:0] valid_q;
  addr_t              tag_q    [ENTRIES];
  addr_t              last_q   [ENTRIES];
  stride_t            stride_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q    [ENTRIES];

  logic             hit;
  logic [IDX_W-1:0] hit_idx, victim_idx, sel_idx;
  stride_t          cand_stride;
  logic             repeat_ok;

  stride_match #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst(rst), .tags(tag_q), .valid(valid_q),
    .key(req_pc), .hit(hit), .hit_idx(hit_idx)
  );

  stride_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(req_valid),
    .touch_idx(sel_idx), .victim_idx(victim_idx)
  );

  assign sel_idx     = hit ? hit_idx : victim_idx;
  assign cand_stride = stride_t'(req_addr - last_q[hit_idx]);
  assign repeat_ok   = hit && (cand_stride != '0) && (cand_stride == stride_q[hit_idx]);

  // entry payload: no reset, plain indexed writes
  always_ff @(posedge clk) begin
    if (req_valid) begin
      tag_q[sel_idx]  <= req_pc;
      last_q[sel_idx] <= req_addr;
      if (!hit) begin
        stride_q[sel_idx] <= '0;
        cnt_q[sel_idx]    <= '0;
      end else if (repeat_ok) begin
        if (cnt_q[sel_idx] != CNT_MAX) cnt_q[sel_idx] <= cnt_q[sel_idx] + 1'b1;
      end else begin
        stride_q[sel_idx] <= cand_stride;
        cnt_q[sel_idx]    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_stride  <= '0;
      rsp_trained <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        valid_q[sel_idx] <= 1'b1;
        rsp_hit          <= hit;
        rsp_trained      <= repeat_ok;
        if (!hit)           rsp_stride <= '0;
        else if (repeat_ok) rsp_stride <= stride_q[hit_idx];
        else                rsp_stride <= cand_stride;
      end
    end
  end

  // saturation watch for the entry just confirmed at its ceiling
  logic             sat_q;
  logic [IDX_W-1:0] sat_idx_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sat_q     <= 1'b0;
      sat_idx_q <= '0;
    end else begin
      sat_q     <= req_valid && repeat_ok && (cnt_q[hit_idx] == CNT_MAX);
      sat_idx_q <= hit_idx;
    end
  end

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (rst)
    sat_q |-> cnt_q[sat_idx_q] == CNT_MAX);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_miss_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_stride == '0 && !rsp_trained));
  assert_trained_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_trained) |-> (rsp_hit && rsp_stride != '0));
  assert_invalid_first_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit && !(&valid_q)) |-> !valid_q[victim_idx]);
endmodule

// File: tb/tb_stride_table.sv
module tb_stride_table;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int CW         = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_pc = '0, req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_trained;
  logic [31:0] rsp_stride;

  stride_table #(.ENTRIES(N), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_stride(rsp_stride), .rsp_trained(rsp_trained)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference: queues ordered most recent first
  logic [31:0] m_pc[$], m_last[$], m_str[$];
  int          m_cnt[$];

  logic        e_valid, e_hit, e_tr;
  logic [31:0] e_str;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [31:0] pc, input logic [31:0] a);
    int idx = -1;
    e_valid = v; e_hit = 0; e_tr = 0; e_str = '0;
    if (!v) return;
    foreach (m_pc[i]) if (m_pc[i] == pc) idx = i;
    if (idx < 0) begin
      if (m_pc.size() == N) begin
        void'(m_pc.pop_back()); void'(m_last.pop_back());
        void'(m_str.pop_back()); void'(m_cnt.pop_back());
      end
      m_pc.push_front(pc); m_last.push_front(a);
      m_str.push_front('0); m_cnt.push_front(0);
    end else begin
      logic [31:0] ns, st;
      int c;
      ns = a - m_last[idx];
      st = m_str[idx];
      c  = m_cnt[idx];
      e_hit = 1;
      if (ns != 0 && ns == st) begin
        if (c < (1 << CW) - 1) c++;
        e_tr = 1;
      end else begin
        st = ns; c = 0;
      end
      e_str = st;
      m_pc.delete(idx); m_last.delete(idx); m_str.delete(idx); m_cnt.delete(idx);
      m_pc.push_front(pc); m_last.push_front(a);
      m_str.push_front(st); m_cnt.push_front(c);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = v; req_pc = pc; req_addr = a;
    model(v, pc, a);
    @(posedge clk);
    #1;
    chk(tag, {31'b0, rsp_valid}, {31'b0, e_valid}, "rsp_valid");
    if (e_valid) begin
      chk(tag, {31'b0, rsp_hit}, {31'b0, e_hit}, "rsp_hit");
      chk(tag, rsp_stride, e_str, "rsp_stride");
      chk(tag, {31'b0, rsp_trained}, {31'b0, e_tr}, "rsp_trained");
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs[6], lst[6];
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk("R1", {31'b0, rsp_valid}, 32'd0, "rsp_valid after reset");
    step(1, 32'hA000, 32'd100, "R1 first lookup misses");
    step(1, 32'hA000, 32'd110, "R4 first stride");
    step(1, 32'hA000, 32'd120, "R5 repeat trains");
    step(1, 32'hA000, 32'd120, "R6 zero stride");
    step(0, 32'hA000, 32'd0,   "R2 idle");
    step(1, 32'hA000, 32'd100, "R6 negative stride");
    step(1, 32'hA000, 32'd80,  "R5 negative repeat");
    step(1, 32'hA000, 32'd90,  "R6 changed stride");
    step(1, 32'hB000, 32'h10,  "R3 new entry");
    step(1, 32'hB000, 32'hFFFF_FFF0, "R4 wrap stride");
    step(1, 32'hC000, 32'd0,   "R7 fill");
    step(1, 32'hD000, 32'd0,   "R7 fill");
    step(1, 32'hA000, 32'd100, "R7 still retained");
    step(1, 32'hB000, 32'hFFFF_FFD0, "R7 still retained");
    step(1, 32'hC000, 32'd8,   "R8 refresh");
    step(1, 32'hE000, 32'd0,   "R8 evict oldest");
    step(1, 32'hD000, 32'd0,   "R8 evicted entry misses");
    step(1, 32'hC000, 32'd16,  "R8 refreshed entry kept");
    for (int k = 0; k < 12; k++)
      step(1, 32'hC000, 32'd24 + 32'(8 * k), "R9 long run");
    step(0, 32'h0, 32'h0, "R2 idle");
    for (int i = 0; i < 6; i++) begin pcs[i] = 32'h100 + 32'(i * 4); lst[i] = 32'(i * 1000); end
    for (int k = 0; k < 3000; k++) begin
      int p = $urandom_range(0, 5);
      int s = $urandom_range(0, 3);
      logic v = ($urandom_range(0, 9) < 8);
      logic [31:0] d;
      d = (s == 0) ? 32'd0 : (s == 1) ? 32'hFFFF_FFC0 : 32'd64;
      if (v) lst[p] = lst[p] + d;
      step(v, pcs[p], lst[p], "R8 random mix");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule